// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Result Pair

This block is the integer multiply and divide engine that sits beside the ALU of a 32-bit RISC pipeline. Its results go to two private result registers rather than to the general register file. The upper register, HI, takes the high half of a product or the remainder of a division. The lower register, LO, takes the low half of a product or the quotient. The core issues an operation with a one-cycle start strobe, an opcode and two operands. The unit then works one bit per clock and reports completion through a busy level and a done pulse.

Multiplication uses a shift-add loop and division uses a restoring loop. Both work on operand magnitudes. For the signed forms, the negative operands are negated on entry and the results are corrected on completion. A multiply-accumulate adds the signed product into the existing HI:LO pair. The core reads the results back through a read port. A read that arrives while an operation is in flight is held off until the result is written.

Top module: `mdu_unit`

## Requirements
- R1: After reset, busy and done are low and both HI and LO read as zero.
- R2: Opcode 0 (signed multiply) writes the two's-complement product of opA and opB to HI:LO, high half in HI.
- R3: Opcode 1 (unsigned multiply) writes the unsigned 2*WIDTH-bit product to HI:LO.
- R4: Opcode 2 (multiply-accumulate) replaces HI:LO with HI:LO plus the signed product, modulo 2^(2*WIDTH).
- R5: Opcode 3 (signed divide) with a non-zero divisor writes the quotient truncated toward zero to LO and the remainder, carrying the sign of the dividend, to HI. The most negative value divided by -1 gives quotient equal to the most negative value and remainder zero.
- R6: Opcode 4 (unsigned divide) with a non-zero divisor writes the unsigned quotient to LO and the remainder to HI.
- R7: A divide by zero (opcode 3 or 4) completes with normal timing, LO all ones and HI equal to opA.
- R8: busy rises in the cycle after the accepting edge. done is a single-cycle pulse that is high together with busy low, in the cycle that follows the (WIDTH+1)-th clock edge after the accepting edge.
- R9: rdData shows HI when rdSel is 1 and LO when rdSel is 0. rdValid equals rdReq while busy is low, and stays low while busy is high.
- R10: A start while busy is high is ignored. A start with opcode 5, 6 or 7 is ignored and does not raise busy. Neither kind of ignored start changes HI or LO.
- R11: HI and LO change only when an operation completes, and done is high in the cycle that follows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Start strobe, sampled when the unit is idle |
| opCode | input | 3 | 0 mul, 1 mulu, 2 mac, 3 div, 4 divu |
| opA | input | WIDTH | Multiplicand or dividend |
| opB | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| rdReq | input | 1 | Read request for HI or LO |
| rdSel | input | 1 | 1 selects HI, 0 selects LO |
| rdValid | output | 1 | Read granted this cycle |
| rdData | output | WIDTH | Selected result register |

## Verification
The assertions assume that the core never raises rdReq expecting data while busy is high. They also assume that opCode and the operands are stable during the cycle in which the start is sampled. The bench drives every input at the falling edge, holds the operands through the accepting edge, and raises its only mid-flight start for exactly one cycle well before completion. The bench uses a 4-bit configuration and sweeps every operand pair for all five opcodes, so sign corrections, the overflow quotient and zero divisors all come up naturally.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;
  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_MULU = 3'd1,
    OP_MAC  = 3'd2,
    OP_DIV  = 3'd3,
    OP_DIVU = 3'd4
  } mduOp_e;

  typedef struct packed {
    logic load;
    logic stepMul;
    logic stepDiv;
    logic commit;
  } mduStrobe_t;
endpackage

// File: rtl/mdu_ctrl.sv
`timescale 1ns/1ps
module mdu_ctrl import mdu_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic [2:0] opCode,
  output mduStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  state_e        state;
  logic [CW-1:0] stepCnt;
  logic          divMode;
  logic          opOk;
  logic          accept;

  assign opOk   = (opCode <= 3'(OP_DIVU));
  assign accept = startValid && (state == S_IDLE) && opOk;
  assign busy   = (state != S_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.stepMul = (state == S_RUN) && !divMode;
    strobe.stepDiv = (state == S_RUN) && divMode;
    strobe.commit  = (state == S_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      divMode <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= (state == S_FIN);
      case (state)
        S_IDLE: if (accept) begin
          state   <= S_RUN;
          stepCnt <= '0;
          divMode <= (opCode == OP_DIV) || (opCode == OP_DIVU);
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdu_dp.sv
`timescale 1ns/1ps
module mdu_dp import mdu_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mduStrobe_t       strobe,
  input  logic [2:0]       opCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] hiQ,
  output logic [WIDTH-1:0] loQ
);
  localparam int W  = WIDTH;
  localparam int DW = 2 * WIDTH;

  // iteration state
  logic [W-1:0] upperR, lowerR, sideR;
  logic         aNegR, bNegR, zeroR, isDivR, isMacR;
  logic [W-1:0] hiR, loR;

  // operand preparation
  logic         sgnOp, aNeg, bNeg;
  logic [W-1:0] magA, magB;

  assign sgnOp = (opCode == OP_MUL) || (opCode == OP_MAC) || (opCode == OP_DIV);
  assign aNeg  = sgnOp && opA[W-1];
  assign bNeg  = sgnOp && opB[W-1];
  assign magA  = aNeg ? (W'(0) - opA) : opA;
  assign magB  = bNeg ? (W'(0) - opB) : opB;

  // shift-add step
  logic [W:0] addend, sumM;
  assign addend = lowerR[0] ? {1'b0, sideR} : '0;
  assign sumM   = {1'b0, upperR} + addend;

  // restoring step
  logic [W:0] shifted, trial;
  assign shifted = {upperR, lowerR[W-1]};
  assign trial   = shifted - {1'b0, sideR};

  // completion: sign correction and accumulate
  logic [DW-1:0] rawProd, prodFix, prodOut;
  logic [W-1:0]  quotFix, remFix;
  logic          flipSign;

  assign flipSign = aNegR ^ bNegR;
  assign rawProd  = {upperR, lowerR};
  assign prodFix  = flipSign ? (DW'(0) - rawProd) : rawProd;
  assign prodOut  = isMacR ? (prodFix + {hiR, loR}) : prodFix;
  assign quotFix  = zeroR ? '1 : (flipSign ? (W'(0) - lowerR) : lowerR);
  assign remFix   = aNegR ? (W'(0) - upperR) : upperR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperR <= '0;
      lowerR <= '0;
      sideR  <= '0;
      aNegR  <= 1'b0;
      bNegR  <= 1'b0;
      zeroR  <= 1'b0;
      isDivR <= 1'b0;
      isMacR <= 1'b0;
      hiR    <= '0;
      loR    <= '0;
    end else begin
      if (strobe.load) begin
        upperR <= '0;
        lowerR <= magA;
        sideR  <= magB;
        aNegR  <= aNeg;
        bNegR  <= bNeg;
        zeroR  <= (opB == '0);
        isDivR <= (opCode == OP_DIV) || (opCode == OP_DIVU);
        isMacR <= (opCode == OP_MAC);
      end else if (strobe.stepMul) begin
        upperR <= sumM[W:1];
        lowerR <= {sumM[0], lowerR[W-1:1]};
      end else if (strobe.stepDiv) begin
        if (!trial[W]) begin
          upperR <= trial[W-1:0];
          lowerR <= {lowerR[W-2:0], 1'b1};
        end else begin
          upperR <= shifted[W-1:0];
          lowerR <= {lowerR[W-2:0], 1'b0};
        end
      end
      if (strobe.commit) begin
        if (isDivR) begin
          hiR <= remFix;
          loR <= quotFix;
        end else begin
          hiR <= prodOut[DW-1:W];
          loR <= prodOut[W-1:0];
        end
      end
    end
  end

  assign hiQ = hiR;
  assign loQ = loR;
endmodule

// File: rtl/mdu_unit.sv
`timescale 1ns/1ps
module mdu_unit import mdu_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [2:0]       opCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  input  logic             rdReq,
  input  logic             rdSel,
  output logic             rdValid,
  output logic [WIDTH-1:0] rdData
);
  mduStrobe_t       strobe;
  logic [WIDTH-1:0] hiQ, loQ;

  mdu_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opCode(opCode),
    .strobe(strobe), .busy(busy), .done(done)
  );

  mdu_dp #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opCode(opCode),
    .opA(opA), .opB(opB), .hiQ(hiQ), .loQ(loQ)
  );

  assign rdValid = rdReq && !busy;
  assign rdData  = rdSel ? hiQ : loQ;
endmodule

// File: rtl/mdu_unit_chk.sv
`timescale 1ns/1ps
module mdu_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startValid,
  input logic [2:0]       opCode,
  input logic             busy,
  input logic             done,
  input logic             rdReq,
  input logic             rdValid,
  input logic [WIDTH-1:0] hiQ,
  input logic [WIDTH-1:0] loQ
);
  int busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
    else busyCnt <= 0;
  end

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R8
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> (busyCnt == WIDTH + 1));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R9
  read_stall_chk: assert property (@(posedge clk) disable iff (!rstN) busy |-> !rdValid);
  // R9
  read_grant_chk: assert property (@(posedge clk) disable iff (!rstN) (rdReq && !busy) |-> rdValid);
  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid && (opCode > 3'd4)) |=> !busy);
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hiQ != $past(hiQ)) || (loQ != $past(loQ))) |-> done);
endmodule

bind mdu_unit mdu_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .startValid(startValid), .opCode(opCode),
  .busy(busy), .done(done), .rdReq(rdReq), .rdValid(rdValid),
  .hiQ(hiQ), .loQ(loQ)
);

// File: tb/mdu_unit_tb.sv
`timescale 1ns/1ps
module mdu_unit_tb_top;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startValid = 1'b0;
  logic [2:0]    opCode = '0;
  logic [TW-1:0] opA = '0, opB = '0;
  logic          busy, done, rdReq = 1'b0, rdSel = 1'b0, rdValid;
  logic [TW-1:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [TW-1:0] hiExp = '0, loExp = '0;

  always #2 clk = ~clk;

  mdu_unit #(.WIDTH(TW)) dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opCode(opCode),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .rdReq(rdReq),
    .rdSel(rdSel), .rdValid(rdValid), .rdData(rdData)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= 2 ** (TW - 1)) ? v - 2 ** TW : v;
  endfunction

  task automatic readBack(input string tag);
    rdReq = 1'b1;
    rdSel = 1'b1;
    #0.5;
    check({tag, " HI (R9)"}, rdData, hiExp);
    check({tag, " grant (R9)"}, rdValid, 1);
    rdSel = 1'b0;
    #0.5;
    check({tag, " LO (R9)"}, rdData, loExp);
    rdReq = 1'b0;
  endtask

  task automatic model(input int op, input int a, input int b);
    longint p;
    logic [63:0] v;
    int q, r;
    case (op)
      0: p = longint'(sx(a)) * sx(b);
      1: p = longint'(a) * b;
      2: p = longint'({hiExp, loExp}) + longint'(sx(a)) * sx(b);
      default: p = 0;
    endcase
    if (op <= 2) begin
      v = p;
      {hiExp, loExp} = v[2*TW-1:0];
    end else if (b == 0) begin
      loExp = '1;
      hiExp = a[TW-1:0];
    end else begin
      if (op == 3) begin q = sx(a) / sx(b); r = sx(a) % sx(b); end
      else begin q = a / b; r = a % b; end
      loExp = q[TW-1:0];
      hiExp = r[TW-1:0];
    end
  endtask

  task automatic runOp(input int op, input int a, input int b, input bit poke);
    int n;
    string tag;
    case (op)
      0: tag = "R2 mul";
      1: tag = "R3 mulu";
      2: tag = "R4 mac";
      3: tag = (b == 0) ? "R7 div0" : "R5 div";
      default: tag = (b == 0) ? "R7 divu0" : "R6 divu";
    endcase
    model(op, a, b);
    @(negedge clk);
    opCode = 3'(op); opA = TW'(a); opB = TW'(b); startValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startValid = 1'b0;
    rdReq = 1'b1;
    check("R8 busy after accept", busy, 1);
    n = 0;
    while (!done && n < 100) begin
      check("R9 stall while busy", rdValid, 0);
      if (poke && n == 1) begin
        startValid = 1'b1; opCode = 3'd1; opA = '1; opB = '1;
      end else startValid = 1'b0;
      @(posedge clk); n++;
      @(negedge clk);
    end
    startValid = 1'b0;
    rdReq = 1'b0;
    check("R8 latency", n, TW + 1);
    check("R8 busy low at done", busy, 0);
    readBack(poke ? {tag, " R10 busy-start"} : tag);
    @(negedge clk);
    check("R8 single pulse", done, 0);
    check("R10 no restart", busy, 0);
  endtask

  task automatic badOp(input int op);
    @(negedge clk);
    opCode = 3'(op); opA = 4'h7; opB = 4'h3; startValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startValid = 1'b0;
    check("R10 bad opcode busy", busy, 0);
    @(negedge clk);
    check("R10 bad opcode done", done, 0);
    readBack("R10 bad opcode");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    readBack("R1 reset");
    for (int op = 0; op < 5; op++) begin
      for (int a = 0; a < 2 ** TW; a++) begin
        for (int b = 0; b < 2 ** TW; b++) begin
          runOp(op, a, b, (b == 5));
        end
      end
      badOp(5 + (op % 3));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule